// File: doc/BRIEF.md
# Byte-Addressed Serial EEPROM Target

This block is the storage side of a 256-byte EEPROM that answers on a two-wire management bus. A separate bus front end turns wire activity into one-cycle events: the start of a transaction with its 7-bit target address and direction, a received write byte, a request for a byte to send back, and a stop. The block keeps one 8-bit byte pointer. In a write transaction the first byte received sets the pointer. Every byte after it is stored at the pointer, and the pointer then moves on. A read request returns the byte at the pointer and moves it on as well. There is no separate random-read phase: a read starts wherever the last write or read left the pointer.

Several copies can share one bus. Each copy has its own target address in the range 0x50 to 0x57 and loads its own 256-byte slice of a computed start-up image. After reset the block copies that slice into the array, one byte per clock, and ignores bus events until the copy is done. A sticky flag shows whether the device has moved any data byte since reset.

The controller has six states. LOAD copies the image and holds `busy` high. IDLE waits for a transaction. W_OFFSET waits for the pointer byte, and W_DATA stores bytes. READ serves read requests. SKIP covers a transaction for another address. The transitions are as follows:
- load_done: LOAD to IDLE.
- start_write_hit: any live state to W_OFFSET.
- start_read_hit: any live state to READ.
- start_miss: any live state to SKIP.
- offset_taken: W_OFFSET to W_DATA.
- stop_seen: any live state to IDLE.

Top module: `byte_eeprom_target`

## Requirements
- R1: After reset `busy` is high for exactly 256 rising edges and the pointer is 0. The array then holds the image, in which byte i of the device at address A is (37*i + 101*(A-0x50) + SEED) mod 256, with SEED = 90. A second reset discards all written data and reloads the image.
- R2: Any event that arrives while `busy` is high has no effect on the data, the pointer, `addr_ack` or `rd_valid`.
- R3: A start event whose address equals the device address raises `addr_ack` for one cycle, on the edge that samples the start. The bus direction bit `bus_rnw` is 1 for a read and 0 for a write.
- R4: The first write byte after a matching write start is loaded into the pointer and is not stored.
- R5: Each later write byte of the same transaction is stored at the pointer, and the pointer then increments modulo 256, so address 0xFF is followed by 0x00.
- R6: A read request in a matching read transaction sets `rd_valid` for one cycle and presents on `rd_data` the byte at the pointer, one edge after the request. The pointer then increments, wrapping from 255 to 0. `rd_data` holds its value between reads.
- R7: A write transaction that carries only the pointer byte moves the pointer and changes no stored data.
- R8: After a start for any other address, no `addr_ack` is given, and the write bytes and read requests that follow change neither the data nor the pointer until the next start.
- R9: `accessed` is 0 after reset. It becomes 1 after the first pointer byte, stored byte or served read, and stays 1 until reset.
- R10: A read request outside a matching read transaction gives no `rd_valid`. A write byte outside a matching write transaction is ignored.
- R11: A stop ends the transaction. A later read continues from the pointer left by the last write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; starts the image copy |
| bus_start | input | 1 | Start event, one cycle |
| bus_addr | input | 7 | Target address qualified by `bus_start` |
| bus_rnw | input | 1 | Direction with `bus_start`: 1 read, 0 write |
| bus_wr_valid | input | 1 | A write byte was received |
| bus_wr_data | input | 8 | Received write byte |
| bus_rd_req | input | 1 | Front end asks for the next byte to send |
| bus_stop | input | 1 | Stop event, one cycle |
| busy | output | 1 | Image copy in progress; events are ignored |
| addr_ack | output | 1 | Matching start seen, one-cycle pulse |
| rd_valid | output | 1 | `rd_data` carries a fresh byte, one-cycle pulse |
| rd_data | output | 8 | Byte returned for the last read request |
| accessed | output | 1 | Sticky flag: data has moved since reset |

## Verification
The hardest cases to reach from the ports are a pointer crossing 0xFF while it stores and while it reads, and events that arrive during the start-up copy. The stimulus covers the first case by sending the pointer byte 0xFE followed by three data bytes, then reading those bytes back across the wrap. It covers the second by asserting reset again in the middle of the run and issuing a full write transaction while `busy` is still high. A later read at pointer 0 shows that neither the pointer nor the data moved. Transactions for neighbouring addresses are also placed between matching ones, and each is followed by a read that continues from the unchanged pointer.

// File: rtl/eeprom_target_pkg.sv
package eeprom_target_pkg;

    typedef enum logic [2:0] {
        ST_LOAD,
        ST_IDLE,
        ST_W_OFFSET,
        ST_W_DATA,
        ST_READ,
        ST_SKIP
    } ctl_state_t;

    // Start-up image word for position idx of slice sl; caller truncates.
    function automatic int unsigned image_word(input int unsigned sl,
                                               input int unsigned idx,
                                               input int unsigned seed);
        return idx * 37 + sl * 101 + seed;
    endfunction

endpackage

// File: rtl/eeprom_image_loader.sv
module eeprom_image_loader #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int SLICE  = 0,
    parameter int SEED   = 90
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              load_done,
    output logic              load_we,
    output logic [ADDR_W-1:0] load_addr,
    output logic [DATA_W-1:0] load_data
);
    import eeprom_target_pkg::*;

    localparam logic [ADDR_W-1:0] LAST = {ADDR_W{1'b1}};

    logic [ADDR_W-1:0] cnt_q;
    logic              done_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (!done_q) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST) begin
                done_q <= 1'b1;
            end
        end
    end

    assign load_done = done_q;
    assign load_we   = !done_q;
    assign load_addr = cnt_q;
    assign load_data = DATA_W'(image_word(SLICE, int'(cnt_q), SEED));

endmodule

// File: rtl/eeprom_store.sv
module eeprom_store #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] word_view [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        logic [DATA_W-1:0] word_q;
        always_ff @(posedge clk) begin
            if (we && (waddr == ADDR_W'(g))) begin
                word_q <= wdata;
            end
        end
        assign word_view[g] = word_q;
    end

    assign rdata = word_view[raddr];

endmodule

// File: rtl/eeprom_bus_ctl.sv
module eeprom_bus_ctl #(
    parameter int          ADDR_W   = 8,
    parameter int          DATA_W   = 8,
    parameter logic [6:0]  DEV_ADDR = 7'h50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_done,
    input  logic              bus_start,
    input  logic [6:0]        bus_addr,
    input  logic              bus_rnw,
    input  logic              bus_wr_valid,
    input  logic [DATA_W-1:0] bus_wr_data,
    input  logic              bus_rd_req,
    input  logic              bus_stop,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              addr_ack,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              accessed
);
    import eeprom_target_pkg::*;

    ctl_state_t        state_q, state_n;
    logic [ADDR_W-1:0] ptr_q;

    // Event decode, priority: start, stop, write byte, read request.
    logic addr_hit, ev_start, ev_stop, ev_wr, ev_rd;
    logic take_offset, take_store, take_read;

    always_comb begin
        addr_hit    = (bus_addr == DEV_ADDR);
        ev_start    = load_done && bus_start;
        ev_stop     = load_done && !bus_start && bus_stop;
        ev_wr       = load_done && !bus_start && !bus_stop && bus_wr_valid;
        ev_rd       = load_done && !bus_start && !bus_stop && !bus_wr_valid
                      && bus_rd_req;
        take_offset = ev_wr && (state_q == ST_W_OFFSET);
        take_store  = ev_wr && (state_q == ST_W_DATA);
        take_read   = ev_rd && (state_q == ST_READ);
    end

    // Next-state logic
    always_comb begin
        state_n = state_q;
        if (!load_done) begin
            state_n = ST_LOAD;
        end else if (ev_start) begin
            if (!addr_hit) begin
                state_n = ST_SKIP;
            end else if (bus_rnw) begin
                state_n = ST_READ;
            end else begin
                state_n = ST_W_OFFSET;
            end
        end else if (ev_stop) begin
            state_n = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_LOAD:     state_n = ST_IDLE;
                ST_W_OFFSET: if (take_offset) state_n = ST_W_DATA;
                ST_IDLE,
                ST_W_DATA,
                ST_READ,
                ST_SKIP:     state_n = state_q;
                default:     state_n = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_LOAD;
        end else begin
            state_q <= state_n;
        end
    end

    // Registered outputs and pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q    <= '0;
            addr_ack <= 1'b0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
            accessed <= 1'b0;
        end else begin
            addr_ack <= ev_start && addr_hit;
            rd_valid <= take_read;
            if (take_offset) begin
                ptr_q    <= ADDR_W'(bus_wr_data);
                accessed <= 1'b1;
            end else if (take_store) begin
                ptr_q    <= ptr_q + 1'b1;
                accessed <= 1'b1;
            end else if (take_read) begin
                rd_data  <= mem_rdata;
                ptr_q    <= ptr_q + 1'b1;
                accessed <= 1'b1;
            end
        end
    end

    assign mem_we    = take_store;
    assign mem_addr  = ptr_q;
    assign mem_wdata = bus_wr_data;

endmodule

// File: rtl/byte_eeprom_target.sv
module byte_eeprom_target #(
    parameter int          ADDR_W    = 8,
    parameter int          DATA_W    = 8,
    parameter logic [6:0]  DEV_ADDR  = 7'h50,
    parameter logic [6:0]  BASE_ADDR = 7'h50,
    parameter int          IMG_SEED  = 90
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_start,
    input  logic [6:0]        bus_addr,
    input  logic              bus_rnw,
    input  logic              bus_wr_valid,
    input  logic [DATA_W-1:0] bus_wr_data,
    input  logic              bus_rd_req,
    input  logic              bus_stop,
    output logic              busy,
    output logic              addr_ack,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              accessed
);
    localparam int SLICE = int'(DEV_ADDR - BASE_ADDR) & 7;

    logic              load_done, load_we, ctl_we, st_we;
    logic [ADDR_W-1:0] load_addr, ctl_addr, st_waddr;
    logic [DATA_W-1:0] load_data, ctl_wdata, st_wdata, st_rdata;

    eeprom_image_loader #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .SLICE  (SLICE),
        .SEED   (IMG_SEED)
    ) u_loader (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_done (load_done),
        .load_we   (load_we),
        .load_addr (load_addr),
        .load_data (load_data)
    );

    assign st_we    = load_we | ctl_we;
    assign st_waddr = load_done ? ctl_addr  : load_addr;
    assign st_wdata = load_done ? ctl_wdata : load_data;

    eeprom_store #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_store (
        .clk   (clk),
        .we    (st_we),
        .waddr (st_waddr),
        .wdata (st_wdata),
        .raddr (ctl_addr),
        .rdata (st_rdata)
    );

    eeprom_bus_ctl #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .DEV_ADDR (DEV_ADDR)
    ) u_ctl (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_done    (load_done),
        .bus_start    (bus_start),
        .bus_addr     (bus_addr),
        .bus_rnw      (bus_rnw),
        .bus_wr_valid (bus_wr_valid),
        .bus_wr_data  (bus_wr_data),
        .bus_rd_req   (bus_rd_req),
        .bus_stop     (bus_stop),
        .mem_rdata    (st_rdata),
        .mem_we       (ctl_we),
        .mem_addr     (ctl_addr),
        .mem_wdata    (ctl_wdata),
        .addr_ack     (addr_ack),
        .rd_valid     (rd_valid),
        .rd_data      (rd_data),
        .accessed     (accessed)
    );

    assign busy = !load_done;

endmodule

// File: rtl/byte_eeprom_target_chk.sv
module byte_eeprom_target_chk #(
    parameter logic [6:0] DEV_ADDR = 7'h50
) (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_start,
    input logic [6:0] bus_addr,
    input logic       bus_rd_req,
    input logic       busy,
    input logic       addr_ack,
    input logic       rd_valid,
    input logic       accessed
);
    // R1
    busy_stays_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> !busy);

    // R2
    quiet_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy) |-> (!addr_ack && !rd_valid));

    // R3
    ack_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_ack |-> ($past(bus_start) && ($past(bus_addr) == DEV_ADDR)));

    // R6
    rd_valid_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(bus_rd_req));

    // R8
    miss_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_start && (bus_addr != DEV_ADDR)) |=> !addr_ack);

    // R9
    accessed_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accessed |=> accessed);

endmodule

bind byte_eeprom_target byte_eeprom_target_chk #(.DEV_ADDR(DEV_ADDR)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_start  (bus_start),
    .bus_addr   (bus_addr),
    .bus_rd_req (bus_rd_req),
    .busy       (busy),
    .addr_ack   (addr_ack),
    .rd_valid   (rd_valid),
    .accessed   (accessed)
);

// File: tb/byte_eeprom_target_test.sv
`timescale 1ns/1ps
module byte_eeprom_target_test;

    localparam logic [6:0] DEV = 7'h53;
    localparam int         SL  = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_start = 1'b0;
    logic [6:0] bus_addr = '0;
    logic       bus_rnw = 1'b0;
    logic       bus_wr_valid = 1'b0;
    logic [7:0] bus_wr_data = '0;
    logic       bus_rd_req = 1'b0;
    logic       bus_stop = 1'b0;
    logic       busy, addr_ack, rd_valid, accessed;
    logic [7:0] rd_data;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    byte_eeprom_target #(.DEV_ADDR(DEV)) uut (
        .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_addr(bus_addr),
        .bus_rnw(bus_rnw), .bus_wr_valid(bus_wr_valid), .bus_wr_data(bus_wr_data),
        .bus_rd_req(bus_rd_req), .bus_stop(bus_stop), .busy(busy),
        .addr_ack(addr_ack), .rd_valid(rd_valid), .rd_data(rd_data),
        .accessed(accessed)
    );

    function automatic int img(input int i);
        return (37 * i + 101 * SL + 90) % 256;
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int        m_mem [256];
    int        m_ptr, m_busy_left, m_mode;   // mode: 0 idle,1 off,2 data,3 read,4 skip
    logic      m_ack, m_rv, m_acc;
    int        m_rd;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) m_mem[i] = img(i);
            m_ptr = 0; m_busy_left = 256; m_mode = 0;
            m_ack = 0; m_rv = 0; m_acc = 0; m_rd = 0;
        end else begin
            m_ack = 0; m_rv = 0;
            if (m_busy_left == 0) begin
                if (bus_start) begin
                    if (bus_addr == DEV) begin
                        m_ack = 1; m_mode = bus_rnw ? 3 : 1;
                    end else m_mode = 4;
                end else if (bus_stop) begin
                    m_mode = 0;
                end else if (bus_wr_valid) begin
                    if (m_mode == 1) begin
                        m_ptr = bus_wr_data; m_mode = 2; m_acc = 1;
                    end else if (m_mode == 2) begin
                        m_mem[m_ptr] = bus_wr_data; m_ptr = (m_ptr + 1) % 256; m_acc = 1;
                    end
                end else if (bus_rd_req && m_mode == 3) begin
                    m_rd = m_mem[m_ptr]; m_rv = 1; m_ptr = (m_ptr + 1) % 256; m_acc = 1;
                end
            end else begin
                m_busy_left--;
            end
        end
    end

    bit run_on = 1'b0;
    always @(negedge clk) begin
        if (rst_n && run_on) begin
            chk("R1 busy per clock", 16'(busy), 16'(m_busy_left > 0));
            chk("R3 addr_ack per clock", 16'(addr_ack), 16'(m_ack));
            chk("R6 rd_valid per clock", 16'(rd_valid), 16'(m_rv));
            chk("R6 rd_data per clock", 16'(rd_data), 16'(m_rd));
            chk("R9 accessed per clock", 16'(accessed), 16'(m_acc));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic start_ev(input logic [6:0] a, input logic rnw, output logic ack);
        @(negedge clk); bus_start = 1; bus_addr = a; bus_rnw = rnw;
        @(negedge clk); bus_start = 0; ack = addr_ack;
    endtask

    task automatic wr_ev(input logic [7:0] d);
        @(negedge clk); bus_wr_valid = 1; bus_wr_data = d;
        @(negedge clk); bus_wr_valid = 0;
    endtask

    task automatic rd_ev(output logic rv, output logic [7:0] d);
        @(negedge clk); bus_rd_req = 1;
        @(negedge clk); bus_rd_req = 0; rv = rd_valid; d = rd_data;
    endtask

    task automatic stop_ev();
        @(negedge clk); bus_stop = 1;
        @(negedge clk); bus_stop = 0;
    endtask

    task automatic read_expect(input string tag, input int exp);
        logic rv; logic [7:0] d;
        rd_ev(rv, d);
        chk(tag, 16'(rv), 16'd1);
        chk(tag, 16'(d), 16'(exp));
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic ack, rv;
        logic [7:0] d;
        repeat (3) @(negedge clk);
        chk("R1 busy in reset", 16'(busy), 16'd1);
        chk("R9 accessed in reset", 16'(accessed), 16'd0);
        rst_n = 1; run_on = 1;
        // R1: busy for exactly 256 edges
        repeat (255) @(negedge clk);
        chk("R1 busy before copy end", 16'(busy), 16'd1);
        @(negedge clk);
        chk("R1 busy after 256 edges", 16'(busy), 16'd0);

        // R3, R6: read from pointer 0
        start_ev(DEV, 1'b1, ack);
        chk("R3 ack on hit", 16'(ack), 16'd1);
        for (int i = 0; i < 4; i++) read_expect("R6 R1 image read", img(i));
        stop_ev();
        chk("R9 accessed after read", 16'(accessed), 16'd1);

        // R4, R5, R11
        start_ev(DEV, 1'b0, ack);
        wr_ev(8'h20); wr_ev(8'h11); wr_ev(8'h22); wr_ev(8'h33);
        stop_ev();
        start_ev(DEV, 1'b1, ack);
        read_expect("R11 read continues after write", img(8'h23));
        stop_ev();

        // R7 offset-only write, R4 offset not stored, R5 stored bytes
        start_ev(DEV, 1'b0, ack);
        wr_ev(8'h20);
        stop_ev();
        start_ev(DEV, 1'b1, ack);
        read_expect("R7 R5 stored byte 0", 8'h11);
        read_expect("R5 stored byte 1", 8'h22);
        read_expect("R4 R5 stored byte 2", 8'h33);
        stop_ev();

        // R5/R6 wrap
        start_ev(DEV, 1'b0, ack);
        wr_ev(8'hFE); wr_ev(8'hA0); wr_ev(8'hA1); wr_ev(8'hA2);
        stop_ev();
        start_ev(DEV, 1'b0, ack);
        wr_ev(8'hFE);
        stop_ev();
        start_ev(DEV, 1'b1, ack);
        read_expect("R5 wrap FE", 8'hA0);
        read_expect("R5 wrap FF", 8'hA1);
        read_expect("R5 R6 wrap 00", 8'hA2);
        read_expect("R6 after wrap", img(1));
        stop_ev();

        // R8 other addresses
        start_ev(7'h54, 1'b0, ack);
        chk("R8 no ack for miss", 16'(ack), 16'd0);
        wr_ev(8'h00); wr_ev(8'h77);
        rd_ev(rv, d);
        chk("R8 no rd_valid for miss", 16'(rv), 16'd0);
        stop_ev();
        start_ev(7'h52, 1'b1, ack);
        chk("R8 no ack for read miss", 16'(ack), 16'd0);
        rd_ev(rv, d);
        chk("R8 no rd_valid for read miss", 16'(rv), 16'd0);
        stop_ev();
        start_ev(DEV, 1'b1, ack);
        read_expect("R8 pointer kept after miss", img(2));
        stop_ev();

        // R10 wrong-direction events
        rd_ev(rv, d);
        chk("R10 no rd_valid when idle", 16'(rv), 16'd0);
        start_ev(DEV, 1'b0, ack);
        wr_ev(8'h40);
        rd_ev(rv, d);
        chk("R10 no rd_valid in write", 16'(rv), 16'd0);
        stop_ev();
        start_ev(DEV, 1'b1, ack);
        wr_ev(8'h99);
        read_expect("R10 write byte ignored in read", img(8'h40));
        stop_ev();

        // R1 reload, R2 events during busy
        @(negedge clk); rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        start_ev(DEV, 1'b0, ack);
        chk("R2 no ack while busy", 16'(ack), 16'd0);
        wr_ev(8'h00); wr_ev(8'hEE);
        stop_ev();
        chk("R9 accessed clear after reset", 16'(accessed), 16'd0);
        while (busy) @(negedge clk);
        start_ev(DEV, 1'b1, ack);
        read_expect("R2 R1 busy write ignored", img(0));
        stop_ev();
        start_ev(DEV, 1'b0, ack);
        wr_ev(8'h20);
        stop_ev();
        start_ev(DEV, 1'b1, ack);
        read_expect("R1 data reloaded", img(8'h20));
        stop_ev();

        repeat (3) @(negedge clk);
        summary();
        $finish;
    end

endmodule